// File: doc/BRIEF.md
# Serial Bus Line Glitch Filter

This block cleans up the clock and data lines of a slave-only two-wire serial bus before a protocol engine sees them. It runs on a system clock that is much faster than the bus bit rate. Each raw line first passes through a two-flop synchronizer. The synchronized value is then shifted into a four-deep sample history on every system clock. A filtered copy of each line moves to a new level only when the history satisfies the voting rule picked by a 2-bit mode input. When the rule is not met, the filtered copy keeps its old level.

Three rules are offered:
- **Two-in-a-row:** the two newest samples agree.
- **Majority:** two of the three newest samples agree.
- **Four-in-a-row:** the four newest samples agree. This rule rejects the longest spikes, but it needs a system clock above sixteen times the bit rate. The other two rules need more than six times the bit rate.

The spare mode code behaves as four-in-a-row. On the filtered lines, the block also flags three events with one-cycle pulses:
- a rising edge of the clock line;
- a bus start, where data falls while the clock line is high;
- a bus stop, where data rises while the clock line is high.

Top module: `bus_line_filter`

## Requirements
- R1: While reset is high and on the first cycle after it, both filtered lines read 1 and all three event pulses read 0.
- R2: A clean level change on a raw line, held steady, shows on its filtered line 5 clock edges after the edge that first captures it with mode 00 or 01, and 7 edges after with mode 10 or 11.
- R3: With mode 00 (two-in-a-row), a filtered line takes a new level only when the two newest samples both hold it. A low spike lasting 1 clock is dropped, and one lasting 2 clocks passes.
- R4: With mode 01 (majority), a filtered line follows the majority of the three newest samples. A 1-clock spike is dropped and a 2-clock spike passes. The raw pattern 0,1,0,1 (one clock each) pulls the line low, while mode 00 keeps it high.
- R5: With mode 10 (four-in-a-row), a filtered line changes only after four agreeing samples. A 3-clock spike is dropped and a 4-clock spike passes.
- R6: Mode 11 behaves exactly as mode 10.
- R7: When the active rule is not satisfied, a filtered line keeps its previous level.
- R8: `scl_rise` is high for exactly one clock each time the filtered clock line goes from 0 to 1.
- R9: `start_det` is high for exactly one clock when the filtered data line falls while the filtered clock line is high in that cycle and in the cycle before.
- R10: `stop_det` is high for exactly one clock when the filtered data line rises while the filtered clock line is high in that cycle and in the cycle before.
- R11: Data line transitions made while the filtered clock line is low produce neither a start pulse nor a stop pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Voting rule: 00 two-in-a-row, 01 majority of three, 10 and 11 four-in-a-row |
| scl_in | input | 1 | Raw bus clock line, asynchronous |
| sda_in | input | 1 | Raw bus data line, asynchronous |
| scl_filt | output | 1 | Filtered bus clock line |
| sda_filt | output | 1 | Filtered bus data line |
| scl_rise | output | 1 | One-cycle pulse on a filtered clock rising edge |
| start_det | output | 1 | One-cycle pulse on a detected start condition |
| stop_det | output | 1 | One-cycle pulse on a detected stop condition |

## Verification
The bench sends spikes that are one clock shorter and exactly as long as each rule's pass width. A design with an off-by-one window would let the short spike through, or would drop the long one. It measures how many edges each rule takes to respond, which catches a missing or extra synchronizer stage. It sends a 0,1,0,1 pattern that only the majority rule turns into a low output, which catches majority and two-in-a-row being swapped. It also moves the data line while the clock line is low, which catches a start or stop detector that ignores the clock level.

// File: rtl/lf_pkg.sv
package lf_pkg;

    typedef enum logic [1:0] {
        VOTE_PAIR = 2'b00,
        VOTE_MAJ3 = 2'b01,
        VOTE_QUAD = 2'b10,
        VOTE_RSVD = 2'b11
    } vote_mode_e;

    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;

    localparam int PAIR_LEN = 2;
    localparam int MAJ_LEN  = 3;
    localparam int QUAD_LEN = 4;

    typedef struct packed {
        logic change;
        logic level;
    } vote_t;

    function automatic logic maj3(input logic [MAJ_LEN-1:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

endpackage

// File: rtl/lf_sync.sv
module lf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lf_vote.sv
module lf_vote
    import lf_pkg::*;
#(
    parameter int   HIST_LEN = QUAD_LEN,
    parameter logic IDLE     = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  vote_mode_e          mode,
    input  logic                smp,
    output logic                filt,
    output logic [HIST_LEN-1:0] hist
);
    vote_t vote;

    always_comb begin
        vote = '{change: 1'b0, level: filt};
        case (mode)
            VOTE_PAIR: begin
                if (&hist[PAIR_LEN-1:0]) begin
                    vote = '{change: 1'b1, level: 1'b1};
                end else if (~|hist[PAIR_LEN-1:0]) begin
                    vote = '{change: 1'b1, level: 1'b0};
                end
            end
            VOTE_MAJ3: begin
                vote = '{change: 1'b1, level: maj3(hist[MAJ_LEN-1:0])};
            end
            default: begin
                if (&hist[QUAD_LEN-1:0]) begin
                    vote = '{change: 1'b1, level: 1'b1};
                end else if (~|hist[QUAD_LEN-1:0]) begin
                    vote = '{change: 1'b1, level: 1'b0};
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= {HIST_LEN{IDLE}};
            filt <= IDLE;
        end else begin
            hist <= {hist[HIST_LEN-2:0], smp};
            if (vote.change) begin
                filt <= vote.level;
            end
        end
    end
endmodule

// File: rtl/lf_event.sv
module lf_event (
    input  logic clk,
    input  logic rst,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  = scl_f & ~scl_q;
    assign start_det = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_det  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/bus_line_filter.sv
module bus_line_filter
    import lf_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HIST_LEN    = QUAD_LEN
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_filt,
    output logic       sda_filt,
    output logic       scl_rise,
    output logic       start_det,
    output logic       stop_det
);
    vote_mode_e             vmode;
    logic [NUM_LINES-1:0]   raw;
    logic [NUM_LINES-1:0]   synced;
    logic [NUM_LINES-1:0]   filt;
    logic [HIST_LEN-1:0]    hist [NUM_LINES];
    logic [HIST_LEN-1:0]    scl_hist;
    logic [HIST_LEN-1:0]    sda_hist;

    assign vmode         = vote_mode_e'(mode);
    assign raw[LINE_SCL] = scl_in;
    assign raw[LINE_SDA] = sda_in;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        lf_sync #(
            .STAGES (SYNC_STAGES),
            .RST_VAL(1'b1)
        ) u_sync (
            .clk(clk),
            .rst(rst),
            .d  (raw[g]),
            .q  (synced[g])
        );

        lf_vote #(
            .HIST_LEN(HIST_LEN),
            .IDLE    (1'b1)
        ) u_vote (
            .clk (clk),
            .rst (rst),
            .mode(vmode),
            .smp (synced[g]),
            .filt(filt[g]),
            .hist(hist[g])
        );
    end

    assign scl_filt = filt[LINE_SCL];
    assign sda_filt = filt[LINE_SDA];
    assign scl_hist = hist[LINE_SCL];
    assign sda_hist = hist[LINE_SDA];

    lf_event u_event (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (scl_filt),
        .sda_f    (sda_filt),
        .scl_rise (scl_rise),
        .start_det(start_det),
        .stop_det (stop_det)
    );
endmodule

// File: rtl/bus_line_filter_chk.sv
module bus_line_filter_chk #(
    parameter int HIST_LEN = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [1:0]          mode,
    input logic [HIST_LEN-1:0] scl_hist,
    input logic [HIST_LEN-1:0] sda_hist,
    input logic                scl_filt,
    input logic                sda_filt,
    input logic                scl_rise,
    input logic                start_det,
    input logic                stop_det
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (scl_filt && sda_filt && !start_det && !stop_det && !scl_rise));

    // R3
    pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && scl_hist[0] != scl_hist[1]) |=> $stable(scl_filt));

    // R4
    maj_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && scl_hist[2:0] == 3'b000) |=> !scl_filt);

    // R5
    quad_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode[1] && !(&sda_hist[3:0]) && (|sda_hist[3:0])) |=> $stable(sda_filt));

    // R8
    rise_edge_chk: assert property (@(posedge clk) disable iff (rst)
        scl_rise |-> (scl_filt && $past(!scl_filt)));

    // R9
    start_cond_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |-> (scl_filt && !sda_filt && $past(sda_filt)));

    // R10
    stop_cond_chk: assert property (@(posedge clk) disable iff (rst)
        stop_det |-> (scl_filt && sda_filt && $past(!sda_filt)));

    // R11
    event_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_det, stop_det}));
endmodule

bind bus_line_filter bus_line_filter_chk #(.HIST_LEN(HIST_LEN)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .scl_hist (scl_hist),
    .sda_hist (sda_hist),
    .scl_filt (scl_filt),
    .sda_filt (sda_filt),
    .scl_rise (scl_rise),
    .start_det(start_det),
    .stop_det (stop_det)
);

// File: tb/bus_line_filter_tb_top.sv
module bus_line_filter_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0] mode;
        logic [3:0] width;
        logic       pass;
        logic [3:0] lat;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 4'd1, 1'b0, 4'd0},
        '{2'b00, 4'd2, 1'b1, 4'd5},
        '{2'b00, 4'd5, 1'b1, 4'd5},
        '{2'b01, 4'd1, 1'b0, 4'd0},
        '{2'b01, 4'd2, 1'b1, 4'd5},
        '{2'b10, 4'd3, 1'b0, 4'd0},
        '{2'b10, 4'd4, 1'b1, 4'd7},
        '{2'b11, 4'd3, 1'b0, 4'd0},
        '{2'b11, 4'd4, 1'b1, 4'd7}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       scl_filt, sda_filt, scl_rise, start_det, stop_det;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_line_filter dut_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_filt (scl_filt),
        .sda_filt (sda_filt),
        .scl_rise (scl_rise),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b00:   return "R3 two-in-a-row";
            2'b01:   return "R4 majority";
            2'b10:   return "R5 four-in-a-row";
            default: return "R6 spare mode";
        endcase
    endfunction

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int lat, rises, starts, stops, low_seen, min_sda;

        // R1: state during and right after reset
        repeat (3) @(negedge clk);
        check("R1 scl_filt in reset", scl_filt, 1);
        check("R1 sda_filt in reset", sda_filt, 1);
        check("R1 pulses in reset", {scl_rise, start_det, stop_det}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 scl_filt after reset", scl_filt, 1);
        check("R1 sda_filt after reset", sda_filt, 1);

        // Table walk: low spike on the clock line, data held high
        for (int v = 0; v < NVEC; v++) begin
            mode = VECS[v].mode;
            settle(12);
            scl_in = 1'b0;
            lat = 0; rises = 0; starts = 0; stops = 0;
            for (int i = 1; i <= 20; i++) begin
                @(negedge clk);
                if (!scl_filt && lat == 0) lat = i;
                if (scl_rise) rises++;
                if (start_det) starts++;
                if (stop_det) stops++;
                if (i == int'(VECS[v].width)) scl_in = 1'b1;
            end
            check({mode_tag(VECS[v].mode), " R7 spike pass"}, int'(lat != 0), int'(VECS[v].pass));
            check("R2 latency", lat, int'(VECS[v].lat));
            check("R8 rise pulse count", rises, int'(VECS[v].pass));
            check("R9 R10 no events from clock spike", starts + stops, 0);
            check("R7 clock line settled high", scl_filt, 1);
        end

        // R4: majority turns 0,1,0,1 into a low output
        mode = 2'b01;
        settle(12);
        low_seen = 0;
        for (int i = 0; i < 16; i++) begin
            scl_in = (i < 4) ? logic'(i[0]) : 1'b1;
            @(negedge clk);
            if (!scl_filt) low_seen = 1;
        end
        check("R4 majority follows 0,1,0,1", low_seen, 1);

        // R3/R7: two-in-a-row holds through the same pattern
        mode = 2'b00;
        settle(12);
        low_seen = 0;
        for (int i = 0; i < 16; i++) begin
            scl_in = (i < 4) ? logic'(i[0]) : 1'b1;
            @(negedge clk);
            if (!scl_filt) low_seen = 1;
        end
        check("R3 R7 pair rule holds on 0,1,0,1", low_seen, 0);

        // R9: start condition with clock high
        settle(12);
        sda_in = 1'b0;
        starts = 0; stops = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (start_det) starts++;
            if (stop_det) stops++;
        end
        check("R9 start pulse count", starts, 1);
        check("R9 no stop on falling data", stops, 0);
        check("R9 data line low", sda_filt, 0);

        // R10: stop condition with clock high
        sda_in = 1'b1;
        starts = 0; stops = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (start_det) starts++;
            if (stop_det) stops++;
        end
        check("R10 stop pulse count", stops, 1);
        check("R10 no start on rising data", starts, 0);

        // R11: data moves while clock is low
        starts = 0; stops = 0; min_sda = 1;
        for (int step = 0; step < 4; step++) begin
            case (step)
                0: scl_in = 1'b0;
                1: sda_in = 1'b0;
                2: sda_in = 1'b1;
                default: scl_in = 1'b1;
            endcase
            for (int i = 0; i < 12; i++) begin
                @(negedge clk);
                if (start_det) starts++;
                if (stop_det) stops++;
                if (!sda_filt) min_sda = 0;
            end
        end
        check("R11 data toggled while clock low", min_sda, 0);
        check("R11 no start or stop", starts + stops, 0);

        // R1: reset in the middle of activity
        sda_in = 1'b0;
        settle(12);
        check("R1 data low before reset", sda_filt, 0);
        rst = 1'b1;
        sda_in = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset data high", sda_filt, 1);
        check("R1 mid-run reset pulses low", {scl_rise, start_det, stop_det}, 0);
        rst = 1'b0;
        settle(4);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule